// File: doc/BRIEF.md
# Receive Mailbox Matching Queue Engine

This block decides where a completed receive frame lands inside a small array of receive mailboxes. Each mailbox keeps an identifier, a two-bit status code and a "released by host" flag. When the protocol engine signals that a frame is complete, every mailbox is compared with the received identifier under an acceptance mask. The lowest-numbered matching mailbox that can take the frame wins. If no matching mailbox can take it, the highest-numbered matching mailbox is overwritten instead. Several mailboxes programmed with one identifier therefore behave as a receive queue that fills in index order.

Acceptance masks come from one of two sources, selected by a mode input. In the first, every mailbox has its own mask. In the second, one shared mask serves most mailboxes and two fixed mailbox positions each have a dedicated mask. The host programs mailboxes through a single write port. It releases a mailbox it has read with a strobe, and acknowledges interrupt bits with write-one-to-clear strobes. A control input can make the block discard frames that the node sent itself. The payload RAM, timestamping, bit-level protocol and transmit arbitration live elsewhere.

Top module: `rx_mbox_queue`

## Requirements
- R1: After reset every mailbox code is INACTIVE (code encoding: 0 INACTIVE, 1 EMPTY, 2 FULL, 3 OVERRUN), all interrupt flags are 0 and `st_valid` is 0. All masks reset to all ones and all identifiers to 0.
- R2: A mailbox matches when, for every identifier bit whose mask bit is 1, the received bit equals the mailbox bit. Identifier bits whose mask bit is 0 are ignored.
- R3: On `rx_done` the frame goes to the lowest-index matching mailbox that is free. A free mailbox is one with code EMPTY, or with code FULL/OVERRUN and its release flag set. That mailbox's code becomes FULL. `st_valid` pulses for exactly the cycle after `rx_done`, with `st_idx` and `st_code` describing the store.
- R4: A matching mailbox that is FULL and not released is skipped, so repeated frames with one identifier fill successive matching mailboxes.
- R5: When no matching mailbox is free, the highest-index matching mailbox is overwritten and its code becomes OVERRUN.
- R6: A `host_release` pulse sets a mailbox's release flag. A released FULL mailbox is free again. The flag clears when the mailbox is stored into or written by the host.
- R7: With `indiv_mask_en`=1 each mailbox uses its own mask. With it 0, mailbox LEG_A (14) uses the mask at `gmask_sel`=1, mailbox LEG_B (15) uses the mask at `gmask_sel`=2, and all others use the shared mask at `gmask_sel`=0.
- R8: When `self_rx_dis`=1, a frame with `rx_self`=1 is stored nowhere, changes no code and sets no interrupt flag.
- R9: A host mailbox write (`cfg_we`) issued between `rx_start` and `rx_done` (including the `rx_done` cycle) removes that mailbox from that round. The write sets the mailbox's code and identifier.
- R10: INACTIVE mailboxes never match. A frame that matches no mailbox changes no code and no flag, and gives no `st_valid`.
- R11: Each store sets the target mailbox's bit in `irq_flags`. A bit clears when its `irq_clr` bit is 1, but a store in the same cycle keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| indiv_mask_en | input | 1 | 1: per-mailbox masks; 0: shared plus two dedicated masks |
| self_rx_dis | input | 1 | 1: discard frames sent by this node |
| cfg_we | input | 1 | Host mailbox write strobe |
| cfg_idx | input | IDX_W | Mailbox written |
| cfg_code | input | 2 | Code written |
| cfg_id | input | ID_W | Identifier written |
| imask_we | input | 1 | Per-mailbox mask write strobe |
| imask_idx | input | IDX_W | Mailbox whose mask is written |
| gmask_we | input | 1 | Shared/dedicated mask write strobe |
| gmask_sel | input | 2 | 0 shared, 1 mailbox LEG_A, 2 mailbox LEG_B, 3 ignored |
| mask_val | input | ID_W | Mask value for either mask write |
| host_release | input | NUM_MB | Per-mailbox release strobes |
| irq_clr | input | NUM_MB | Write-one-to-clear for interrupt flags |
| rx_start | input | 1 | Start of a matching round |
| rx_done | input | 1 | Frame complete, match decision point |
| rx_id | input | ID_W | Received identifier |
| rx_self | input | 1 | Frame was sent by this node |
| st_valid | output | 1 | Store performed |
| st_idx | output | IDX_W | Stored mailbox index |
| st_code | output | 2 | New code of the stored mailbox |
| irq_flags | output | NUM_MB | Per-mailbox interrupt flags |
| mb_codes | output | 2*NUM_MB | Code of mailbox i at bits [2i+1:2i] |

## Verification
The bench builds the block with its defaults: 16 mailboxes, 11-bit identifiers, and dedicated legacy masks on mailboxes 14 and 15. With these values the mailboxes that use the two dedicated masks lie within the random and directed scans. Random identifiers are drawn from a four-value pool and masks from a few patterns, so identical-identifier queues, overruns and partial-mask matches recur many times across both mask modes.

// File: rtl/rx_mbox_pkg.sv
package rx_mbox_pkg;
   typedef enum logic [1:0] {
      MB_INACTIVE = 2'd0,
      MB_EMPTY    = 2'd1,
      MB_FULL     = 2'd2,
      MB_OVERRUN  = 2'd3
   } mb_code_e;

   localparam logic [1:0] GSEL_SHARED = 2'd0;
   localparam logic [1:0] GSEL_LEG_A  = 2'd1;
   localparam logic [1:0] GSEL_LEG_B  = 2'd2;
endpackage

// File: rtl/rx_mbox_mask_sel.sv
module rx_mbox_mask_sel #(
   parameter int NUM_MB = 16,
   parameter int ID_W   = 11,
   parameter int LEG_A  = 14,
   parameter int LEG_B  = 15
) (
   input  logic                           indiv_en,
   input  logic [NUM_MB-1:0][ID_W-1:0]    imask,
   input  logic [ID_W-1:0]                shared_mask,
   input  logic [ID_W-1:0]                leg_a_mask,
   input  logic [ID_W-1:0]                leg_b_mask,
   output logic [NUM_MB-1:0][ID_W-1:0]    eff_mask
);
   for (genvar i = 0; i < NUM_MB; i++) begin : g_mb
      logic [ID_W-1:0] legacy;
      if (i == LEG_A) begin : g_a
         assign legacy = leg_a_mask;
      end else if (i == LEG_B) begin : g_b
         assign legacy = leg_b_mask;
      end else begin : g_s
         assign legacy = shared_mask;
      end
      assign eff_mask[i] = indiv_en ? imask[i] : legacy;
   end
endmodule

// File: rtl/rx_mbox_match.sv
module rx_mbox_match
   import rx_mbox_pkg::*;
#(
   parameter int NUM_MB = 16,
   parameter int ID_W   = 11
) (
   input  logic [ID_W-1:0]                rx_id,
   input  logic [NUM_MB-1:0][ID_W-1:0]    mb_id,
   input  logic [NUM_MB-1:0][ID_W-1:0]    eff_mask,
   input  logic [NUM_MB-1:0][1:0]         mb_code,
   input  logic [NUM_MB-1:0]              released,
   input  logic [NUM_MB-1:0]              excluded,
   output logic [NUM_MB-1:0]              hit,
   output logic [NUM_MB-1:0]              hit_free
);
   for (genvar i = 0; i < NUM_MB; i++) begin : g_cmp
      logic id_ok, active, can_take;
      assign id_ok    = ((rx_id ^ mb_id[i]) & eff_mask[i]) == '0;
      assign active   = (mb_code[i] != MB_INACTIVE) && !excluded[i];
      assign can_take = (mb_code[i] == MB_EMPTY) ||
                        (((mb_code[i] == MB_FULL) || (mb_code[i] == MB_OVERRUN)) && released[i]);
      assign hit[i]      = id_ok && active;
      assign hit_free[i] = id_ok && active && can_take;
   end
endmodule

// File: rtl/rx_mbox_pick.sv
module rx_mbox_pick #(
   parameter int NUM_MB = 16,
   parameter int IDX_W  = 4
) (
   input  logic [NUM_MB-1:0] hit,
   input  logic [NUM_MB-1:0] hit_free,
   output logic              any_hit,
   output logic              any_free,
   output logic [IDX_W-1:0]  first_free,
   output logic [IDX_W-1:0]  last_hit
);
   always_comb begin
      any_free   = 1'b0;
      first_free = '0;
      for (int i = NUM_MB - 1; i >= 0; i--) begin
         if (hit_free[i]) begin
            any_free   = 1'b1;
            first_free = IDX_W'(i);
         end
      end
   end

   always_comb begin
      any_hit  = 1'b0;
      last_hit = '0;
      for (int i = 0; i < NUM_MB; i++) begin
         if (hit[i]) begin
            any_hit  = 1'b1;
            last_hit = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rx_mbox_queue.sv
module rx_mbox_queue
   import rx_mbox_pkg::*;
#(
   parameter int NUM_MB = 16,
   parameter int ID_W   = 11,
   parameter int LEG_A  = 14,
   parameter int LEG_B  = 15,
   localparam int IDX_W = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 indiv_mask_en,
   input  logic                 self_rx_dis,
   input  logic                 cfg_we,
   input  logic [IDX_W-1:0]     cfg_idx,
   input  logic [1:0]           cfg_code,
   input  logic [ID_W-1:0]      cfg_id,
   input  logic                 imask_we,
   input  logic [IDX_W-1:0]     imask_idx,
   input  logic                 gmask_we,
   input  logic [1:0]           gmask_sel,
   input  logic [ID_W-1:0]      mask_val,
   input  logic [NUM_MB-1:0]    host_release,
   input  logic [NUM_MB-1:0]    irq_clr,
   input  logic                 rx_start,
   input  logic                 rx_done,
   input  logic [ID_W-1:0]      rx_id,
   input  logic                 rx_self,
   output logic                 st_valid,
   output logic [IDX_W-1:0]     st_idx,
   output logic [1:0]           st_code,
   output logic [NUM_MB-1:0]    irq_flags,
   output logic [2*NUM_MB-1:0]  mb_codes
);
   if (NUM_MB < 2) begin : g_bad_num
      $error("rx_mbox_queue: NUM_MB must be at least 2");
   end
   if (ID_W < 1) begin : g_bad_idw
      $error("rx_mbox_queue: ID_W must be positive");
   end
   if (LEG_A >= NUM_MB || LEG_B >= NUM_MB || LEG_A == LEG_B || LEG_A < 0 || LEG_B < 0) begin : g_bad_leg
      $error("rx_mbox_queue: LEG_A/LEG_B must be distinct valid mailbox indices");
   end

   logic [NUM_MB-1:0][ID_W-1:0] mb_id_q;
   logic [NUM_MB-1:0][ID_W-1:0] imask_q;
   logic [NUM_MB-1:0][1:0]      mb_code_q;
   logic [NUM_MB-1:0]           rel_q;
   logic [ID_W-1:0]             shared_q, leg_a_q, leg_b_q;
   logic                        round_q;
   logic [NUM_MB-1:0]           round_excl_q;

   logic [NUM_MB-1:0][ID_W-1:0] eff_mask;
   logic [NUM_MB-1:0]           wr_oh, excluded, hit, hit_free, store_oh;
   logic                        any_hit, any_free, accept;
   logic [IDX_W-1:0]            first_free, last_hit, tgt;
   logic [1:0]                  new_code;

   always_comb begin
      wr_oh = '0;
      if (cfg_we) wr_oh[cfg_idx] = 1'b1;
   end

   assign excluded = round_excl_q | wr_oh;

   rx_mbox_mask_sel #(.NUM_MB(NUM_MB), .ID_W(ID_W), .LEG_A(LEG_A), .LEG_B(LEG_B)) u_msel (
      .indiv_en    (indiv_mask_en),
      .imask       (imask_q),
      .shared_mask (shared_q),
      .leg_a_mask  (leg_a_q),
      .leg_b_mask  (leg_b_q),
      .eff_mask    (eff_mask)
   );

   rx_mbox_match #(.NUM_MB(NUM_MB), .ID_W(ID_W)) u_match (
      .rx_id    (rx_id),
      .mb_id    (mb_id_q),
      .eff_mask (eff_mask),
      .mb_code  (mb_code_q),
      .released (rel_q),
      .excluded (excluded),
      .hit      (hit),
      .hit_free (hit_free)
   );

   rx_mbox_pick #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_pick (
      .hit        (hit),
      .hit_free   (hit_free),
      .any_hit    (any_hit),
      .any_free   (any_free),
      .first_free (first_free),
      .last_hit   (last_hit)
   );

   assign accept   = rx_done && any_hit && !(rx_self && self_rx_dis);
   assign tgt      = any_free ? first_free : last_hit;
   assign new_code = any_free ? MB_FULL : MB_OVERRUN;

   always_comb begin
      store_oh = '0;
      if (accept) store_oh[tgt] = 1'b1;
   end

   // per-mailbox state
   for (genvar i = 0; i < NUM_MB; i++) begin : g_state
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mb_code_q[i] <= MB_INACTIVE;
            mb_id_q[i]   <= '0;
            rel_q[i]     <= 1'b0;
         end else if (wr_oh[i]) begin
            mb_code_q[i] <= cfg_code;
            mb_id_q[i]   <= cfg_id;
            rel_q[i]     <= 1'b0;
         end else if (store_oh[i]) begin
            mb_code_q[i] <= new_code;
            rel_q[i]     <= 1'b0;
         end else if (host_release[i]) begin
            rel_q[i]     <= 1'b1;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            imask_q[i] <= '1;
         end else if (imask_we && imask_idx == IDX_W'(i)) begin
            imask_q[i] <= mask_val;
         end
      end

      assign mb_codes[2*i +: 2] = mb_code_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shared_q <= '1;
         leg_a_q  <= '1;
         leg_b_q  <= '1;
      end else if (gmask_we) begin
         case (gmask_sel)
            GSEL_SHARED: shared_q <= mask_val;
            GSEL_LEG_A:  leg_a_q  <= mask_val;
            GSEL_LEG_B:  leg_b_q  <= mask_val;
            default: ;
         endcase
      end
   end

   // matching round tracking
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         round_q      <= 1'b0;
         round_excl_q <= '0;
      end else if (rx_done) begin
         round_q      <= 1'b0;
         round_excl_q <= '0;
      end else if (rx_start) begin
         round_q      <= 1'b1;
         round_excl_q <= wr_oh;
      end else if (round_q) begin
         round_excl_q <= round_excl_q | wr_oh;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flags <= '0;
         st_valid  <= 1'b0;
         st_idx    <= '0;
         st_code   <= MB_INACTIVE;
      end else begin
         irq_flags <= (irq_flags & ~irq_clr) | store_oh;
         st_valid  <= accept;
         if (accept) begin
            st_idx  <= tgt;
            st_code <= new_code;
         end
      end
   end
endmodule

// File: rtl/rx_mbox_queue_chk.sv
module rx_mbox_queue_chk #(
   parameter int NUM_MB = 16,
   parameter int IDX_W  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                self_rx_dis,
   input logic                rx_done,
   input logic                rx_self,
   input logic                st_valid,
   input logic [IDX_W-1:0]    st_idx,
   input logic [1:0]          st_code,
   input logic [NUM_MB-1:0]   irq_flags,
   input logic [2*NUM_MB-1:0] mb_codes
);
   logic [2*NUM_MB-1:0] prev_codes;
   logic [1:0]          prev_tgt_code, cur_tgt_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_codes <= '0;
      else        prev_codes <= mb_codes;
   end

   assign prev_tgt_code = prev_codes[st_idx*2 +: 2];
   assign cur_tgt_code  = mb_codes[st_idx*2 +: 2];

   p_store_after_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> $past(rx_done));

   p_store_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> (st_code == 2'd2 || st_code == 2'd3) && cur_tgt_code == st_code);

   p_overrun_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_valid && st_code == 2'd3) |-> (prev_tgt_code == 2'd2 || prev_tgt_code == 2'd3));

   p_self_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_done && rx_self && self_rx_dis) |=> !st_valid);

   p_no_inactive_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> prev_tgt_code != 2'd0);

   p_irq_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
      st_valid |-> irq_flags[st_idx]);
endmodule

bind rx_mbox_queue rx_mbox_queue_chk #(.NUM_MB(NUM_MB), .IDX_W(IDX_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .self_rx_dis (self_rx_dis),
   .rx_done     (rx_done),
   .rx_self     (rx_self),
   .st_valid    (st_valid),
   .st_idx      (st_idx),
   .st_code     (st_code),
   .irq_flags   (irq_flags),
   .mb_codes    (mb_codes)
);

// File: tb/sim_rx_mbox_queue.sv
`timescale 1ns/1ps
module sim_rx_mbox_queue;
   localparam int NMB = 16;
   localparam int IDW = 11;
   localparam int LA  = 14;
   localparam int LB  = 15;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic indiv_mask_en = 1'b1, self_rx_dis = 1'b0;
   logic cfg_we = 1'b0; logic [3:0] cfg_idx = '0; logic [1:0] cfg_code = '0; logic [IDW-1:0] cfg_id = '0;
   logic imask_we = 1'b0; logic [3:0] imask_idx = '0;
   logic gmask_we = 1'b0; logic [1:0] gmask_sel = '0; logic [IDW-1:0] mask_val = '0;
   logic [NMB-1:0] host_release = '0, irq_clr = '0;
   logic rx_start = 1'b0, rx_done = 1'b0, rx_self = 1'b0; logic [IDW-1:0] rx_id = '0;
   logic st_valid; logic [3:0] st_idx; logic [1:0] st_code;
   logic [NMB-1:0] irq_flags; logic [2*NMB-1:0] mb_codes;

   always #5 clk = ~clk;

   rx_mbox_queue u0 (
      .clk(clk), .rst_n(rst_n), .indiv_mask_en(indiv_mask_en), .self_rx_dis(self_rx_dis),
      .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_code(cfg_code), .cfg_id(cfg_id),
      .imask_we(imask_we), .imask_idx(imask_idx), .gmask_we(gmask_we), .gmask_sel(gmask_sel),
      .mask_val(mask_val), .host_release(host_release), .irq_clr(irq_clr),
      .rx_start(rx_start), .rx_done(rx_done), .rx_id(rx_id), .rx_self(rx_self),
      .st_valid(st_valid), .st_idx(st_idx), .st_code(st_code),
      .irq_flags(irq_flags), .mb_codes(mb_codes)
   );

   // reference model state
   logic [1:0]     m_code [NMB];
   logic [IDW-1:0] m_id   [NMB];
   logic [IDW-1:0] m_im   [NMB];
   logic           m_rel  [NMB];
   logic [IDW-1:0] m_g, m_a, m_b;
   logic [NMB-1:0] m_irq;

   int checks = 0, failures = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2*NMB-1:0] exp_codes();
      logic [2*NMB-1:0] v;
      for (int i = 0; i < NMB; i++) v[2*i +: 2] = m_code[i];
      return v;
   endfunction

   function automatic void predict(input logic [IDW-1:0] id, input bit self, input logic [NMB-1:0] excl,
                                   output bit v, output int idx, output logic [1:0] code);
      int ff = -1, lh = -1;
      for (int i = 0; i < NMB; i++) begin
         logic [IDW-1:0] mk;
         bit h, fr;
         mk = indiv_mask_en ? m_im[i] : (i == LA ? m_a : (i == LB ? m_b : m_g));
         h  = (m_code[i] != 2'd0) && !excl[i] && (((id ^ m_id[i]) & mk) == '0);
         fr = (m_code[i] == 2'd1) || (m_code[i] >= 2'd2 && m_rel[i]);
         if (h) lh = i;
         if (h && fr && ff < 0) ff = i;
      end
      v = (lh >= 0) && !(self && self_rx_dis);
      idx = (ff >= 0) ? ff : lh;
      code = (ff >= 0) ? 2'd2 : 2'd3;
   endfunction

   task automatic wr_mb(input int idx, input logic [1:0] code, input logic [IDW-1:0] id);
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_code = code; cfg_id = id;
      @(negedge clk);
      cfg_we = 1'b0;
      m_code[idx] = code; m_id[idx] = id; m_rel[idx] = 1'b0;
   endtask

   task automatic wr_imask(input int idx, input logic [IDW-1:0] v);
      @(negedge clk);
      imask_we = 1'b1; imask_idx = 4'(idx); mask_val = v;
      @(negedge clk);
      imask_we = 1'b0;
      m_im[idx] = v;
   endtask

   task automatic wr_gmask(input logic [1:0] sel, input logic [IDW-1:0] v);
      @(negedge clk);
      gmask_we = 1'b1; gmask_sel = sel; mask_val = v;
      @(negedge clk);
      gmask_we = 1'b0;
      if (sel == 2'd0) m_g = v; else if (sel == 2'd1) m_a = v; else if (sel == 2'd2) m_b = v;
   endtask

   task automatic release_mb(input logic [NMB-1:0] r);
      @(negedge clk);
      host_release = r;
      @(negedge clk);
      host_release = '0;
      for (int i = 0; i < NMB; i++) if (r[i]) m_rel[i] = 1'b1;
   endtask

   task automatic clear_irq(input logic [NMB-1:0] c, input string req);
      @(negedge clk);
      irq_clr = c;
      @(negedge clk);
      irq_clr = '0;
      m_irq = m_irq & ~c;
      chk(irq_flags == m_irq, req, "irq after clear", 64'(irq_flags), 64'(m_irq));
   endtask

   task automatic frame(input logic [IDW-1:0] id, input bit self, input int widx,
                        input logic [1:0] wcode, input logic [IDW-1:0] wid,
                        input logic [NMB-1:0] clr, input string req);
      logic [NMB-1:0] excl;
      bit ev; int ei; logic [1:0] ec;
      excl = '0;
      @(negedge clk);
      rx_start = 1'b1;
      @(negedge clk);
      rx_start = 1'b0;
      if (widx >= 0) begin
         cfg_we = 1'b1; cfg_idx = 4'(widx); cfg_code = wcode; cfg_id = wid;
         excl[widx] = 1'b1;
         m_code[widx] = wcode; m_id[widx] = wid; m_rel[widx] = 1'b0;
      end
      @(negedge clk);
      cfg_we = 1'b0;
      rx_done = 1'b1; rx_id = id; rx_self = self; irq_clr = clr;
      predict(id, self, excl, ev, ei, ec);
      @(negedge clk);
      rx_done = 1'b0; rx_self = 1'b0; irq_clr = '0;
      m_irq = m_irq & ~clr;
      if (ev) begin
         m_code[ei] = ec; m_rel[ei] = 1'b0; m_irq[ei] = 1'b1;
      end
      chk(st_valid == ev, req, "st_valid", 64'(st_valid), 64'(ev));
      if (ev) begin
         chk(st_idx == 4'(ei), req, "st_idx", 64'(st_idx), 64'(ei));
         chk(st_code == ec, req, "st_code", 64'(st_code), 64'(ec));
      end
      chk(mb_codes == exp_codes(), req, "codes", 64'(mb_codes), 64'(exp_codes()));
      chk(irq_flags == m_irq, req, "irq", 64'(irq_flags), 64'(m_irq));
      @(negedge clk);
      chk(st_valid == 1'b0, req, "st_valid one cycle", 64'(st_valid), 64'd0);
   endtask

   task automatic all_inactive();
      for (int i = 0; i < NMB; i++) wr_mb(i, 2'd0, '0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'h0C0FFEE5));
      for (int i = 0; i < NMB; i++) begin
         m_code[i] = 2'd0; m_id[i] = '0; m_im[i] = '1; m_rel[i] = 1'b0;
      end
      m_g = '1; m_a = '1; m_b = '1; m_irq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(mb_codes == '0, "R1", "codes", 64'(mb_codes), 64'd0);
      chk(irq_flags == '0, "R1", "irq", 64'(irq_flags), 64'd0);
      chk(st_valid == 1'b0, "R1", "st_valid", 64'(st_valid), 64'd0);

      // R3/R4/R5/R6 queue of two mailboxes
      wr_mb(2, 2'd1, 11'h123);
      wr_mb(5, 2'd1, 11'h123);
      frame(11'h123, 0, -1, 0, 0, '0, "R3");
      frame(11'h123, 0, -1, 0, 0, '0, "R4");
      frame(11'h123, 0, -1, 0, 0, '0, "R5");
      release_mb(16'h0004);
      frame(11'h123, 0, -1, 0, 0, '0, "R6");

      // R10 inactive and unmatched
      wr_mb(7, 2'd0, 11'h124);
      frame(11'h124, 0, -1, 0, 0, '0, "R10");

      // R2 partial mask
      wr_mb(9, 2'd1, 11'h300);
      wr_imask(9, 11'h700);
      frame(11'h3A5, 0, -1, 0, 0, '0, "R2");
      frame(11'h4A5, 0, -1, 0, 0, '0, "R2");

      // R8 self reception
      wr_mb(11, 2'd1, 11'h055);
      self_rx_dis = 1'b1;
      frame(11'h055, 1, -1, 0, 0, '0, "R8");
      self_rx_dis = 1'b0;
      frame(11'h055, 1, -1, 0, 0, '0, "R8");

      // R9 host write during round
      wr_mb(12, 2'd1, 11'h222);
      wr_mb(13, 2'd1, 11'h222);
      frame(11'h222, 0, 12, 2'd1, 11'h222, '0, "R9");
      frame(11'h222, 0, -1, 0, 0, '0, "R9");

      // R11 irq clear and set-wins
      clear_irq(16'h0004, "R11");
      wr_mb(0, 2'd1, 11'h0AA);
      frame(11'h0AA, 0, -1, 0, 0, 16'h0001, "R11");

      // R7 legacy masks
      all_inactive();
      indiv_mask_en = 1'b0;
      wr_gmask(2'd0, 11'h000);
      wr_mb(3, 2'd1, 11'h000);
      wr_mb(LA, 2'd1, 11'h050);
      wr_mb(LB, 2'd1, 11'h060);
      frame(11'h050, 0, -1, 0, 0, '0, "R7");
      frame(11'h050, 0, -1, 0, 0, '0, "R7");
      frame(11'h060, 0, -1, 0, 0, '0, "R7");
      frame(11'h061, 0, -1, 0, 0, '0, "R7");
      wr_gmask(2'd1, 11'h000);
      release_mb(16'h4000);
      frame(11'h7FF, 0, -1, 0, 0, '0, "R7");

      // random phase
      for (int n = 0; n < 600; n++) begin
         int op;
         op = int'($urandom_range(0, 11));
         case (op)
            0, 1: wr_mb(int'($urandom_range(0, NMB-1)),
                        ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'd1,
                        11'h100 + 11'($urandom_range(0, 3)));
            2: release_mb(16'($urandom));
            3: wr_imask(int'($urandom_range(0, NMB-1)),
                        ($urandom_range(0, 2) == 0) ? 11'h7FF : (($urandom_range(0, 1) == 0) ? 11'h7FC : 11'h7FE));
            4: wr_gmask(2'($urandom_range(0, 3)), ($urandom_range(0, 1) == 0) ? 11'h7FF : 11'h7FD);
            5: begin
               @(negedge clk);
               indiv_mask_en = 1'($urandom);
               self_rx_dis = 1'($urandom);
            end
            6: clear_irq(16'($urandom), "R11");
            7: frame(11'h100 + 11'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, NMB-1)),
                     2'd1, 11'h100 + 11'($urandom_range(0, 3)), 16'($urandom), "R9");
            default: frame(11'h100 + 11'($urandom_range(0, 3)), 1'($urandom), -1, 0, 0,
                           16'($urandom), "R3");
         endcase
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule